// File: doc/BRIEF.md
# EPP Cycle Gate with Peripheral Timeout

This block sits between a byte-addressed host register port and a peripheral-side byte transfer channel of an enhanced parallel port. Host accesses to the address and data windows start peripheral byte transfers only when the stored control register holds the exact pattern for the requested direction. Otherwise a write is dropped and a read returns all ones. Data-window accesses may be 8, 16 or 32 bits wide. They are broken into byte transfers, least significant byte first. Every byte transfer waits for a peripheral acknowledge. If none arrives within `TIMEOUT_CYC` cycles, the transfer fails, the rest of the access is abandoned, and a sticky timeout flag is set.

The flag replaces bit 0 of the status value read from offset 1. Writing offset 1 with bit 0 set clears it. The block also handles writes to the data port and the control register. A write whose value matches the stored one causes no peripheral traffic. A control write that flips the direction bit first sends a separate direction transfer, then sends the control value.

A sequencer with four states runs each access:
- `S_IDLE` accepts a request.
- `S_DIR` carries the direction transfer.
- `S_XFER` carries one byte transfer at a time.
- `S_DONE` presents the result for one cycle.

Its transitions are:
- accept: `S_IDLE` goes to `S_XFER`, `S_DIR` or `S_DONE`, depending on the decoded access.
- `S_DIR` goes to `S_XFER` on acknowledge, or to `S_DONE` on expiry.
- `S_XFER` goes to `S_XFER` on acknowledge of a byte that is not the last.
- `S_XFER` goes to `S_DONE` on acknowledge of the last byte, or on expiry.
- `S_DONE` returns to `S_IDLE` unconditionally.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset:
  - host_busy is 0.
  - Offset 2 reads 0xCC in byte 0.
  - The timeout flag is 0.
  - The stored data port value is 0xFF, so a write of 0xFF to offset 0 starts no transfer.
- R2: A write to offset 3 (EPP address) or offset 4 (EPP data) starts transfers only when (control AND 0x2F) equals 0x04. Otherwise no per_req is raised and host_done follows in the next cycle.
- R3: A read of offset 3 or 4 starts transfers only when (control AND 0x2F) equals 0x24. Otherwise host_rdata is 0xFFFFFFFF and no per_req is raised.
- R4: The EPP transfer kinds and byte order are as follows:
  - host_size 0, 1 and 2 move 1, 2 and 4 bytes at offset 4; offset 3 always moves 1 byte.
  - Byte i of a write carries host_wdata[8i+7:8i], and byte i of a read lands in host_rdata[8i+7:8i].
  - Read bytes that are not transferred read as 0xFF.
  - per_kind is 4 for an address write, 5 for an address read, 6 for a data write and 7 for a data read.
- R5: Each byte holds per_req for at most TIMEOUT_CYC cycles.
  - An acknowledge in the last of those cycles still succeeds.
  - With no acknowledge by then, the timeout flag is set, the remaining bytes are not requested, and their read positions stay 0xFF.
- R6: A read of offset 1 returns per_status with bit 0 replaced by the timeout flag. The flag stays set until offset 1 is written with bit 0 = 1; a write with bit 0 = 0 leaves it set.
- R7: A write to offset 0 equal to the stored data value starts no transfer. The same holds for a write to offset 2 whose value ORed with 0xC0 equals the stored control value.
- R8: Control writes behave as follows:
  - A control write stores value OR 0xC0, which offset 2 reads back.
  - The peripheral receives it as a control transfer (per_kind 2) carrying that value with bit 5 cleared.
  - When bit 5 (direction) changes, a direction transfer (per_kind 3, per_wdata = new direction in bit 0) is acknowledged first.
- R9: Host and peripheral handshake:
  - A request is accepted when host_req is high and host_busy is low.
  - host_busy is high from the cycle after acceptance through the single host_done cycle.
  - per_req is high only while busy, and holds its kind and data steady until acknowledged or expired.
- R10: Data port and unused offsets:
  - A changed write to offset 0 sends per_kind 0 with the byte.
  - A read of offset 0 sends per_kind 1 and returns the acknowledged byte.
  - Offsets 5 to 7 read 0xFFFFFFFF, and writes to them start no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | Access width code (0: 8, 1: 16, 2: 32 bits) |
| host_wdata | input | 32 | Write data |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with host_done |
| per_req | output | 1 | Byte transfer request, held until acknowledge or expiry |
| per_kind | output | 3 | Transfer kind code |
| per_wdata | output | 8 | Byte sent to the peripheral |
| per_ack | input | 1 | Peripheral acknowledge for the current byte |
| per_rdata | input | 8 | Byte returned by the peripheral with per_ack |
| per_status | input | 8 | Peripheral status lines |

## Verification
The bench samples outputs on the falling edge. For an access that needs no peripheral traffic (gated, suppressed, status, control read, unused offset), host_done is due on the first falling edge after the accepting rising edge, so the bench checks a latency of exactly one cycle. For a transfer, per_req appears in the cycle after acceptance or after the previous acknowledge, and host_done comes in the cycle after the last acknowledge. On expiry the bench counts exactly TIMEOUT_CYC cycles of per_req and then host_done one cycle later. The bench's peripheral model records every acknowledged byte with its kind, so ordering, suppression and abort are all checked against that log.

// File: rtl/epg_pkg.sv
`timescale 1ns/1ps
package epg_pkg;

    typedef enum logic [2:0] {
        XK_DATA_WR = 3'd0,
        XK_DATA_RD = 3'd1,
        XK_CTRL_WR = 3'd2,
        XK_DIR     = 3'd3,
        XK_EADR_WR = 3'd4,
        XK_EADR_RD = 3'd5,
        XK_EDAT_WR = 3'd6,
        XK_EDAT_RD = 3'd7
    } xfer_kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DIR  = 2'd1,
        S_XFER = 2'd2,
        S_DONE = 2'd3
    } seq_state_e;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CTRL = 3'd2;
    localparam logic [2:0] OFS_EADR = 3'd3;
    localparam logic [2:0] OFS_EDAT = 3'd4;

    localparam logic [7:0] CTRL_SIG_MASK = 8'h2F;
    localparam logic [7:0] GATE_WR_PAT   = 8'h04;
    localparam logic [7:0] GATE_RD_PAT   = 8'h24;
    localparam logic [7:0] CTRL_FIXED    = 8'hC0;
    localparam logic [7:0] CTRL_RST      = 8'hCC;
    localparam logic [7:0] DATA_RST      = 8'hFF;
    localparam int         DIR_BIT       = 5;

    function automatic logic is_read_kind(xfer_kind_e k);
        return (k == XK_DATA_RD) || (k == XK_EADR_RD) || (k == XK_EDAT_RD);
    endfunction

endpackage

// File: rtl/epg_regs.sv
`timescale 1ns/1ps
module epg_regs
    import epg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_data_en,
    input  logic       wr_ctrl_en,
    input  logic       wr_stat_en,
    input  logic [7:0] wval,
    input  logic       set_tout,
    output logic [7:0] ctrl_q,
    output logic [7:0] data_q,
    output logic       tout_q,
    output logic       wr_gate_ok,
    output logic       rd_gate_ok
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            data_q <= DATA_RST;
            tout_q <= 1'b0;
        end else begin
            if (wr_ctrl_en) ctrl_q <= wval | CTRL_FIXED;
            if (wr_data_en) data_q <= wval;
            if (set_tout)
                tout_q <= 1'b1;
            else if (wr_stat_en && wval[0])
                tout_q <= 1'b0;
        end
    end

    always_comb begin
        wr_gate_ok = (ctrl_q & CTRL_SIG_MASK) == GATE_WR_PAT;
        rd_gate_ok = (ctrl_q & CTRL_SIG_MASK) == GATE_RD_PAT;
    end

endmodule

// File: rtl/epg_timer.sv
`timescale 1ns/1ps
module epg_timer #(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic expire
);

    localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run || ack)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb expire = run && !ack && (cnt_q == LAST);

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ack) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/epg_seq.sv
`timescale 1ns/1ps
module epg_seq
    import epg_pkg::*;
#(
    parameter int HOST_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_req,
    input  logic                    host_we,
    input  logic [2:0]              host_addr,
    input  logic [1:0]              host_size,
    input  logic [8*HOST_BYTES-1:0] host_wdata,
    output logic                    busy,
    output logic                    done,
    output logic [8*HOST_BYTES-1:0] rdata,
    input  logic [7:0]              ctrl_q,
    input  logic [7:0]              data_q,
    input  logic                    tout_q,
    input  logic                    wr_gate_ok,
    input  logic                    rd_gate_ok,
    output logic                    wr_data_en,
    output logic                    wr_ctrl_en,
    output logic                    wr_stat_en,
    output logic                    set_tout,
    input  logic                    expire,
    output logic                    per_req,
    output logic [2:0]              per_kind,
    output logic [7:0]              per_wdata,
    input  logic                    per_ack,
    input  logic [7:0]              per_rdata,
    input  logic [7:0]              per_status
);

    localparam int HOST_W = 8 * HOST_BYTES;
    localparam int IDXW   = (HOST_BYTES > 1) ? $clog2(HOST_BYTES) : 1;

    seq_state_e         state_q, state_d;
    xfer_kind_e         kind_q, acc_kind;
    logic [IDXW-1:0]    idx_q, last_q, acc_last, size_last;
    logic [HOST_W-1:0]  wbuf_q, acc_wbuf, acc_rbuf;
    logic               dir_q;
    logic               accept;
    seq_state_e         acc_go;
    logic [7:0]         ctrl_new;
    logic               byte_ok, last_byte;

    always_comb accept = host_req && (state_q == S_IDLE);

    always_comb begin
        size_last = '0;
        for (int b = 1; b < HOST_BYTES; b++)
            if (b < (1 << host_size)) size_last = IDXW'(b);
    end

    // access decode: start state and latched transfer description
    always_comb begin
        ctrl_new = host_wdata[7:0] | CTRL_FIXED;
        acc_go   = S_DONE;
        acc_kind = XK_DATA_WR;
        acc_last = '0;
        acc_wbuf = host_wdata;
        acc_rbuf = '1;
        case (host_addr)
            OFS_DATA: begin
                if (host_we) begin
                    if (host_wdata[7:0] != data_q) begin
                        acc_go   = S_XFER;
                        acc_kind = XK_DATA_WR;
                    end
                end else begin
                    acc_go   = S_XFER;
                    acc_kind = XK_DATA_RD;
                end
            end
            OFS_STAT: begin
                if (!host_we) begin
                    acc_rbuf[7:0] = per_status;
                    acc_rbuf[0]   = tout_q;
                end
            end
            OFS_CTRL: begin
                if (host_we) begin
                    if (ctrl_new != ctrl_q) begin
                        acc_kind         = XK_CTRL_WR;
                        acc_wbuf[7:0]    = ctrl_new;
                        acc_wbuf[DIR_BIT] = 1'b0;
                        acc_go = (ctrl_new[DIR_BIT] != ctrl_q[DIR_BIT]) ? S_DIR : S_XFER;
                    end
                end else begin
                    acc_rbuf[7:0] = ctrl_q;
                end
            end
            OFS_EADR: begin
                if (host_we && wr_gate_ok) begin
                    acc_go   = S_XFER;
                    acc_kind = XK_EADR_WR;
                end else if (!host_we && rd_gate_ok) begin
                    acc_go   = S_XFER;
                    acc_kind = XK_EADR_RD;
                end
            end
            OFS_EDAT: begin
                acc_last = size_last;
                if (host_we && wr_gate_ok) begin
                    acc_go   = S_XFER;
                    acc_kind = XK_EDAT_WR;
                end else if (!host_we && rd_gate_ok) begin
                    acc_go   = S_XFER;
                    acc_kind = XK_EDAT_RD;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        wr_data_en = accept && host_we && (host_addr == OFS_DATA);
        wr_ctrl_en = accept && host_we && (host_addr == OFS_CTRL);
        wr_stat_en = accept && host_we && (host_addr == OFS_STAT);
    end

    always_comb begin
        byte_ok   = (state_q == S_XFER) && per_ack;
        last_byte = (idx_q == last_q);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = acc_go;
            S_DIR: begin
                if (per_ack)     state_d = S_XFER;
                else if (expire) state_d = S_DONE;
            end
            S_XFER: begin
                if (per_ack && last_byte) state_d = S_DONE;
                else if (expire)          state_d = S_DONE;
            end
            S_DONE: state_d = S_IDLE;
        endcase
    end

    // transfer description registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= XK_DATA_WR;
            last_q <= '0;
            idx_q  <= '0;
            wbuf_q <= '0;
            dir_q  <= 1'b0;
        end else if (accept) begin
            kind_q <= acc_kind;
            last_q <= acc_last;
            idx_q  <= '0;
            wbuf_q <= acc_wbuf;
            dir_q  <= ctrl_new[DIR_BIT];
        end else if (byte_ok && !last_byte) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // read-back byte lanes
    for (genvar g = 0; g < HOST_BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= 8'hFF;
            else if (accept)
                lane_q <= acc_rbuf[8*g +: 8];
            else if (byte_ok && is_read_kind(kind_q) && (idx_q == IDXW'(g)))
                lane_q <= per_rdata;
        end
        assign rdata[8*g +: 8] = lane_q;
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_DONE);
        per_req   = (state_q == S_DIR) || (state_q == S_XFER);
        per_kind  = (state_q == S_DIR) ? XK_DIR : kind_q;
        per_wdata = (state_q == S_DIR) ? {7'b0, dir_q} : wbuf_q[{idx_q, 3'b000} +: 8];
        set_tout  = per_req && expire;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !per_req); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && !per_ack && !expire) |=> (per_req && $stable(per_kind) && $stable(per_wdata))); // R9
    AST_DIR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_DIR) && per_ack) |=> (per_req && per_kind == XK_CTRL_WR)); // R8

endmodule

// File: rtl/epp_cycle_gate.sv
`timescale 1ns/1ps
module epp_cycle_gate
    import epg_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16,
    parameter int HOST_BYTES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_req,
    input  logic                    host_we,
    input  logic [2:0]              host_addr,
    input  logic [1:0]              host_size,
    input  logic [8*HOST_BYTES-1:0] host_wdata,
    output logic                    host_busy,
    output logic                    host_done,
    output logic [8*HOST_BYTES-1:0] host_rdata,
    output logic                    per_req,
    output logic [2:0]              per_kind,
    output logic [7:0]              per_wdata,
    input  logic                    per_ack,
    input  logic [7:0]              per_rdata,
    input  logic [7:0]              per_status
);

    logic [7:0] ctrl_q, data_q;
    logic       tout_q, wr_gate_ok, rd_gate_ok;
    logic       wr_data_en, wr_ctrl_en, wr_stat_en, set_tout, expire;

    epg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (wr_data_en),
        .wr_ctrl_en (wr_ctrl_en),
        .wr_stat_en (wr_stat_en),
        .wval       (host_wdata[7:0]),
        .set_tout   (set_tout),
        .ctrl_q     (ctrl_q),
        .data_q     (data_q),
        .tout_q     (tout_q),
        .wr_gate_ok (wr_gate_ok),
        .rd_gate_ok (rd_gate_ok)
    );

    epg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (per_req),
        .ack    (per_ack),
        .expire (expire)
    );

    epg_seq #(.HOST_BYTES(HOST_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_size  (host_size),
        .host_wdata (host_wdata),
        .busy       (host_busy),
        .done       (host_done),
        .rdata      (host_rdata),
        .ctrl_q     (ctrl_q),
        .data_q     (data_q),
        .tout_q     (tout_q),
        .wr_gate_ok (wr_gate_ok),
        .rd_gate_ok (rd_gate_ok),
        .wr_data_en (wr_data_en),
        .wr_ctrl_en (wr_ctrl_en),
        .wr_stat_en (wr_stat_en),
        .set_tout   (set_tout),
        .expire     (expire),
        .per_req    (per_req),
        .per_kind   (per_kind),
        .per_wdata  (per_wdata),
        .per_ack    (per_ack),
        .per_rdata  (per_rdata),
        .per_status (per_status)
    );

    logic acc_t, epp_win;
    always_comb begin
        acc_t   = host_req && !host_busy;
        epp_win = (host_addr == OFS_EADR) || (host_addr == OFS_EDAT);
    end

    AST_GATE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_t && host_we && epp_win && ((ctrl_q & CTRL_SIG_MASK) != GATE_WR_PAT)) |=> !per_req); // R2
    AST_GATE_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_t && !host_we && epp_win && ((ctrl_q & CTRL_SIG_MASK) != GATE_RD_PAT))
        |=> (!per_req && host_done && host_rdata == '1)); // R3
    AST_TOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_q && !(acc_t && host_we && host_addr == OFS_STAT && host_wdata[0])) |=> tout_q); // R6
    AST_TOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tout_q && !(per_req && expire)) |=> !tout_q); // R5

endmodule

// File: tb/epp_cycle_gate_bench.sv
`timescale 1ns/1ps
module epp_cycle_gate_bench;

    localparam int BT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_busy, host_done;
    logic [31:0] host_rdata;
    logic        per_req;
    logic [2:0]  per_kind;
    logic [7:0]  per_wdata;
    logic        per_ack = 1'b0;
    logic [7:0]  per_rdata = 8'h00;
    logic [7:0]  per_status = 8'hB7;

    always #2.5 clk = ~clk;

    epp_cycle_gate #(.TIMEOUT_CYC(BT), .HOST_BYTES(4)) u_epp_cycle_gate (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_done(host_done), .host_rdata(host_rdata),
        .per_req(per_req), .per_kind(per_kind), .per_wdata(per_wdata),
        .per_ack(per_ack), .per_rdata(per_rdata), .per_status(per_status)
    );

    int checks = 0, errors = 0;
    logic finished = 1'b0;

    // peripheral model
    int ack_delay = 0, ack_limit = -1, wc = 0;
    int log_n = 0, mark = 0, req_cycles = 0, rc_base = 0;
    logic [2:0] log_kind [64];
    logic [7:0] log_data [64];

    always @(negedge clk) begin
        if (!rst_n) begin
            per_ack = 1'b0;
            wc = 0;
        end else begin
            if (per_req) req_cycles++;
            if (per_ack) begin
                per_ack = 1'b0;
                wc = per_req ? 1 : 0;
            end else if (per_req) begin
                if ((ack_limit < 0 || log_n < ack_limit) && wc >= ack_delay) begin
                    per_ack = 1'b1;
                    per_rdata = 8'hA0 + 8'(log_n - mark);
                    log_kind[log_n % 64] = per_kind;
                    log_data[log_n % 64] = per_wdata;
                    log_n++;
                end else begin
                    wc++;
                end
            end else begin
                wc = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_log(input string tag, input int i, input logic [2:0] k, input logic [7:0] d);
        chk({tag, " kind"}, 32'(log_kind[(mark + i) % 64]), 32'(k));
        chk({tag, " data"}, 32'(log_data[(mark + i) % 64]), 32'(d));
    endtask

    task automatic access(input logic we, input logic [2:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        mark = log_n;
        rc_base = req_cycles;
        host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
        @(posedge clk);
        #1 host_req = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_done && lat < 500);
        rd = host_rdata;
        @(negedge clk);
    endtask

    logic [31:0] rd;
    int lat;

    task automatic t_reset();
        chk("R1 busy after reset", 32'(host_busy), 32'd0);
        access(1'b0, 3'd2, 2'd0, 32'h0, rd, lat);
        chk("R1 control reset", rd, 32'hFFFFFFCC);
        chk("R9 immediate latency", 32'(lat), 32'd1);
        per_status = 8'hB7;
        access(1'b0, 3'd1, 2'd0, 32'h0, rd, lat);
        chk("R1 R6 status with clear flag", rd, 32'hFFFFFFB6);
        access(1'b1, 3'd0, 2'd0, 32'hFF, rd, lat);
        chk("R1 R7 data reset suppress", 32'(log_n - mark), 32'd0);
    endtask

    task automatic t_gate_closed();
        access(1'b1, 3'd4, 2'd2, 32'h12345678, rd, lat);
        chk("R2 write gated count", 32'(log_n - mark), 32'd0);
        chk("R2 write gated latency", 32'(lat), 32'd1);
        access(1'b0, 3'd3, 2'd0, 32'h0, rd, lat);
        chk("R3 read gated data", rd, 32'hFFFFFFFF);
        chk("R3 read gated count", 32'(log_n - mark), 32'd0);
    endtask

    task automatic t_ctrl_plain();
        access(1'b1, 3'd2, 2'd0, 32'h04, rd, lat);
        chk("R8 ctrl write count", 32'(log_n - mark), 32'd1);
        chk_log("R8 ctrl write", 0, 3'd2, 8'hC4);
        access(1'b0, 3'd2, 2'd0, 32'h0, rd, lat);
        chk("R8 ctrl readback", rd, 32'hFFFFFFC4);
        access(1'b1, 3'd2, 2'd0, 32'h04, rd, lat);
        chk("R7 ctrl equal", 32'(log_n - mark), 32'd0);
        access(1'b1, 3'd2, 2'd0, 32'hC4, rd, lat);
        chk("R7 ctrl equal forced bits", 32'(log_n - mark), 32'd0);
    endtask

    task automatic t_epp_write();
        access(1'b1, 3'd4, 2'd2, 32'h11223344, rd, lat);
        chk("R4 word write count", 32'(log_n - mark), 32'd4);
        chk_log("R4 word b0", 0, 3'd6, 8'h44);
        chk_log("R4 word b1", 1, 3'd6, 8'h33);
        chk_log("R4 word b2", 2, 3'd6, 8'h22);
        chk_log("R4 word b3", 3, 3'd6, 8'h11);
        access(1'b1, 3'd4, 2'd1, 32'h0000BEEF, rd, lat);
        chk("R4 half write count", 32'(log_n - mark), 32'd2);
        chk_log("R4 half b0", 0, 3'd6, 8'hEF);
        chk_log("R4 half b1", 1, 3'd6, 8'hBE);
        access(1'b1, 3'd3, 2'd0, 32'h5C, rd, lat);
        chk("R2 addr write count", 32'(log_n - mark), 32'd1);
        chk_log("R2 addr write", 0, 3'd4, 8'h5C);
        access(1'b0, 3'd4, 2'd2, 32'h0, rd, lat);
        chk("R3 read in write mode", rd, 32'hFFFFFFFF);
    endtask

    task automatic t_dir();
        access(1'b1, 3'd2, 2'd0, 32'h24, rd, lat);
        chk("R8 dir change count", 32'(log_n - mark), 32'd2);
        chk_log("R8 dir first", 0, 3'd3, 8'h01);
        chk_log("R8 ctrl after dir", 1, 3'd2, 8'hC4);
        access(1'b0, 3'd2, 2'd0, 32'h0, rd, lat);
        chk("R8 ctrl readback dir", rd, 32'hFFFFFFE4);
    endtask

    task automatic t_epp_read();
        access(1'b0, 3'd4, 2'd2, 32'h0, rd, lat);
        chk("R4 word read", rd, 32'hA3A2A1A0);
        chk_log("R4 word read kind", 3, 3'd7, log_data[(mark + 3) % 64]);
        access(1'b0, 3'd4, 2'd1, 32'h0, rd, lat);
        chk("R4 half read", rd, 32'hFFFFA1A0);
        access(1'b0, 3'd3, 2'd0, 32'h0, rd, lat);
        chk("R4 addr read", rd, 32'hFFFFFFA0);
        chk_log("R4 addr read kind", 0, 3'd5, log_data[mark % 64]);
        access(1'b1, 3'd4, 2'd0, 32'h77, rd, lat);
        chk("R2 write in read mode", 32'(log_n - mark), 32'd0);
    endtask

    task automatic t_timeout();
        ack_limit = log_n;
        access(1'b0, 3'd3, 2'd0, 32'h0, rd, lat);
        chk("R5 timeout read data", rd, 32'hFFFFFFFF);
        chk("R5 request cycles", 32'(req_cycles - rc_base), 32'(BT));
        chk("R5 timeout latency", 32'(lat), 32'(BT + 1));
        ack_limit = -1;
        per_status = 8'hB6;
        access(1'b0, 3'd1, 2'd0, 32'h0, rd, lat);
        chk("R6 flag in status", rd, 32'hFFFFFFB7);
        access(1'b1, 3'd1, 2'd0, 32'h00, rd, lat);
        access(1'b0, 3'd1, 2'd0, 32'h0, rd, lat);
        chk("R6 flag kept on bit0=0 write", rd, 32'hFFFFFFB7);
        access(1'b1, 3'd1, 2'd0, 32'h01, rd, lat);
        access(1'b0, 3'd1, 2'd0, 32'h0, rd, lat);
        chk("R6 flag cleared", rd, 32'hFFFFFFB6);
    endtask

    task automatic t_abort();
        ack_limit = log_n + 1;
        access(1'b0, 3'd4, 2'd2, 32'h0, rd, lat);
        chk("R5 abort read data", rd, 32'hFFFFFFA0);
        chk("R5 abort byte count", 32'(log_n - mark), 32'd1);
        ack_limit = -1;
        access(1'b0, 3'd1, 2'd0, 32'h0, rd, lat);
        chk("R5 abort sets flag", 32'(rd[0]), 32'd1);
        access(1'b1, 3'd1, 2'd0, 32'h01, rd, lat);
    endtask

    task automatic t_stall();
        ack_delay = BT - 1;
        access(1'b0, 3'd4, 2'd1, 32'h0, rd, lat);
        chk("R5 ack in last cycle", rd, 32'hFFFFA1A0);
        access(1'b0, 3'd1, 2'd0, 32'h0, rd, lat);
        chk("R5 no flag on late ack", 32'(rd[0]), 32'd0);
        ack_delay = BT;
        access(1'b0, 3'd4, 2'd0, 32'h0, rd, lat);
        chk("R5 ack one cycle late", rd, 32'hFFFFFFFF);
        ack_delay = 0;
        access(1'b1, 3'd1, 2'd0, 32'h01, rd, lat);
    endtask

    task automatic t_dir_back();
        access(1'b1, 3'd2, 2'd0, 32'h04, rd, lat);
        chk("R8 dir back count", 32'(log_n - mark), 32'd2);
        chk_log("R8 dir back first", 0, 3'd3, 8'h00);
        chk_log("R8 dir back ctrl", 1, 3'd2, 8'hC4);
    endtask

    task automatic t_data_port();
        access(1'b1, 3'd0, 2'd0, 32'h3C, rd, lat);
        chk("R10 data write count", 32'(log_n - mark), 32'd1);
        chk_log("R10 data write", 0, 3'd0, 8'h3C);
        access(1'b1, 3'd0, 2'd0, 32'h3C, rd, lat);
        chk("R7 data equal", 32'(log_n - mark), 32'd0);
        access(1'b0, 3'd0, 2'd0, 32'h0, rd, lat);
        chk("R10 data read", rd, 32'hFFFFFFA0);
        chk("R10 data read kind", 32'(log_kind[mark % 64]), 32'd1);
        access(1'b0, 3'd6, 2'd0, 32'h0, rd, lat);
        chk("R10 unused read", rd, 32'hFFFFFFFF);
        access(1'b1, 3'd6, 2'd0, 32'h99, rd, lat);
        chk("R10 unused write", 32'(log_n - mark), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate_closed();
        t_ctrl_plain();
        t_epp_write();
        t_dir();
        t_epp_read();
        t_timeout();
        t_abort();
        t_stall();
        t_dir_back();
        t_data_port();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule